// File: doc/BRIEF.md
# Four-Way Set-Associative Page Translation Cache

This block caches recent page translations for a paging unit. A 32-bit linear address enters on the lookup port; the upper 20 bits form the virtual page number, and bits [14:12] of it select one of 8 sets. The block compares the page number against the four ways of that set. One clock later it reports a hit with the 32-bit physical address, built from the stored 20-bit frame number and the unchanged 12-bit page offset, together with the entry's three access attributes. On a miss it reports a clean zero response.

The page-table walker sits outside this block. When it has resolved a miss, it writes the translation back through the fill port. The fill first uses an invalid way of the target set. When the set is full, a per-set round-robin pointer picks the victim. A fill for a page that is already resident rewrites that entry in place. A flush input drops every translation in a single cycle, for example after the page tables have been switched. The block holds 32 entries of 4 KB pages, which is 128 KB of reach.

Top module: `tlb4w`

## Requirements
- R1: After reset, rsp_vld_o, rsp_hit_o, rsp_phys_o and rsp_attr_o are all zero, every entry is invalid, and any lookup misses.
- R2: A lookup request with no fill request in the same cycle produces rsp_vld_o = 1 exactly one clock later. With no such request, rsp_vld_o is 0 and rsp_hit_o is 0.
- R3: A lookup hits when a valid entry in set lkp_lin_i[14:12] holds page number lkp_lin_i[31:12]. The response is then rsp_phys_o = {frame, lkp_lin_i[11:0]}, and rsp_attr_o is the stored attribute field, encoded as bit 2 dirty, bit 1 user-accessible, bit 0 writable.
- R4: On a miss, rsp_hit_o, rsp_phys_o and rsp_attr_o are all zero.
- R5: When a fill and a lookup are requested in the same cycle, the fill is performed and the lookup is dropped, so rsp_vld_o is 0 the following cycle.
- R6: A filled translation is returned by lookups issued from the cycle after the fill onward.
- R7: A fill into a set that has an invalid way writes the lowest-numbered invalid way and evicts nothing.
- R8: A fill of a new page into a full set evicts the way named by that set's 2-bit round-robin pointer. The pointer starts at way 0 and advances by one, wrapping around, only on such an eviction.
- R9: A fill for a page number that is already resident in its set overwrites that entry's frame and attributes. No other entry is evicted, and no page is ever held twice.
- R10: A flush pulse invalidates all 32 entries in one cycle, and lookups issued from the next cycle onward miss. A fill in the flush cycle is discarded. A lookup in the flush cycle is answered from the contents as they stood before the flush.
- R11: Each set has its own round-robin pointer, so evictions in one set do not change which way is evicted next in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lkp_req_i | input | 1 | Lookup request |
| lkp_lin_i | input | 32 | Linear address to translate |
| fill_req_i | input | 1 | Write one translation |
| fill_vpn_i | input | 20 | Page number of the translation |
| fill_pfn_i | input | 20 | Frame number of the translation |
| fill_attr_i | input | 3 | Attributes {dirty, user, writable} |
| rsp_vld_o | output | 1 | Response valid, one cycle after an accepted lookup |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_phys_o | output | 32 | Physical address on a hit, zero on a miss |
| rsp_attr_o | output | 3 | Stored attributes on a hit, zero on a miss |

## Verification
On every cycle the assertions check the following:
- an accepted lookup is answered in the next cycle, and a colliding fill suppresses the answer;
- a miss leaves the address and attributes at zero;
- a hit carries the offset bits through;
- no two ways of a set ever match the same page;
- the first lookup after a flush misses.

Only the directed scenarios can show which entry a fill actually replaces, because that depends on a history of fills in one set. This covers invalid-first placement, the round-robin order and its independence between sets, and in-place refresh of a resident page. They also show that a lookup in the flush cycle still sees the old contents.

// File: rtl/tlb4w_pkg.sv
// Shared types for the translation cache.
// Assumes: attribute field order {dirty, user, writable} from MSB to LSB.
package tlb4w_pkg;
    typedef struct packed {
        logic dirty;
        logic user;
        logic writable;
    } tlb_attr_t;
endpackage

// File: rtl/tlb4w_way.sv
// One way of the cache: per-set valid bit, page number, frame number, attributes.
// Assumes: flush has priority over a write in the same cycle; read is combinational.
module tlb4w_way
    import tlb4w_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [VPN_W-1:0] wr_vpn_i,
    input  logic [PFN_W-1:0] wr_pfn_i,
    input  tlb_attr_t        wr_attr_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic [VPN_W-1:0] rd_vpn_o,
    output logic [PFN_W-1:0] rd_pfn_o,
    output tlb_attr_t        rd_attr_o
);
    logic [SETS-1:0] valid_q;
    logic [VPN_W-1:0] vpn_q  [SETS];
    logic [PFN_W-1:0] pfn_q  [SETS];
    tlb_attr_t        attr_q [SETS];

    // Valid bits: cleared by reset or flush, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
        end
    end

    // Payload storage: written on a non-flush write, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en_i && !flush_i) begin
            vpn_q[wr_idx_i]  <= wr_vpn_i;
            pfn_q[wr_idx_i]  <= wr_pfn_i;
            attr_q[wr_idx_i] <= wr_attr_i;
        end
    end

    // Read port: selected set.
    always_comb begin
        rd_valid_o = valid_q[rd_idx_i];
        rd_vpn_o   = vpn_q[rd_idx_i];
        rd_pfn_o   = pfn_q[rd_idx_i];
        rd_attr_o  = attr_q[rd_idx_i];
    end
endmodule

// File: rtl/tlb4w_victim.sv
// Victim selection: lowest invalid way, else the per-set round-robin pointer.
// Assumes: WAYS is a power of two; the pointer advances only when it is used.
module tlb4w_victim #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic             commit_i,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] ptr_q [SETS];
    logic [WAY_W-1:0] free_way;
    logic             any_free;

    // Find the lowest-numbered invalid way.
    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
        way_o = any_free ? free_way : ptr_q[idx_i];
    end

    // Round-robin pointers: step on an eviction from a full set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (commit_i && !any_free) begin
            ptr_q[idx_i] <= ptr_q[idx_i] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb4w.sv
// Set-associative translation cache top: one shared read of the selected set,
// tag compare, fill placement and registered lookup response.
// Assumes: fill beats lookup in a cycle; flush beats fill; reads see pre-flush state.
module tlb4w
    import tlb4w_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int OFS_W = 12,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int LIN_W = VPN_W + OFS_W,
    localparam int PHY_W = PFN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             lkp_req_i,
    input  logic [LIN_W-1:0] lkp_lin_i,
    input  logic             fill_req_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i,
    input  logic [2:0]       fill_attr_i,
    output logic             rsp_vld_o,
    output logic             rsp_hit_o,
    output logic [PHY_W-1:0] rsp_phys_o,
    output logic [2:0]       rsp_attr_o
);
    logic [VPN_W-1:0] cmp_vpn;
    logic [IDX_W-1:0] idx;
    logic             fill_go, lkp_go, any_hit, evict_commit;
    logic [WAYS-1:0]  rd_valid, hit_vec, wr_en;
    logic [VPN_W-1:0] rd_vpn  [WAYS];
    logic [PFN_W-1:0] rd_pfn  [WAYS];
    tlb_attr_t        rd_attr [WAYS];
    logic [WAY_W-1:0] hit_way, victim_way, wr_way;
    logic [PFN_W-1:0] sel_pfn;
    tlb_attr_t        sel_attr;

    // Port arbitration: the fill owns the single read of the set.
    always_comb begin
        fill_go = fill_req_i && !flush_i;
        lkp_go  = lkp_req_i && !fill_req_i;
        cmp_vpn = fill_req_i ? fill_vpn_i : lkp_lin_i[LIN_W-1:OFS_W];
        idx     = cmp_vpn[IDX_W-1:0];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb4w_way #(.SETS(SETS), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush_i),
            .wr_en_i   (wr_en[w]),
            .wr_idx_i  (idx),
            .wr_vpn_i  (fill_vpn_i),
            .wr_pfn_i  (fill_pfn_i),
            .wr_attr_i (tlb_attr_t'(fill_attr_i)),
            .rd_idx_i  (idx),
            .rd_valid_o(rd_valid[w]),
            .rd_vpn_o  (rd_vpn[w]),
            .rd_pfn_o  (rd_pfn[w]),
            .rd_attr_o (rd_attr[w])
        );
        // Tag compare for this way.
        assign hit_vec[w] = rd_valid[w] && (rd_vpn[w] == cmp_vpn);
        // Write enable for this way.
        assign wr_en[w]   = fill_go && (wr_way == WAY_W'(w));
    end

    // Hit encode and data select across the ways.
    always_comb begin
        hit_way  = '0;
        sel_pfn  = '0;
        sel_attr = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way  = WAY_W'(w);
                sel_pfn  = sel_pfn | rd_pfn[w];
                sel_attr = sel_attr | rd_attr[w];
            end
        end
        any_hit      = |hit_vec;
        evict_commit = fill_go && !any_hit;
        wr_way       = any_hit ? hit_way : victim_way;
    end

    tlb4w_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (idx),
        .valid_i (rd_valid),
        .commit_i(evict_commit),
        .way_o   (victim_way)
    );

    // Response register: one cycle after an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_o  <= 1'b0;
            rsp_hit_o  <= 1'b0;
            rsp_phys_o <= '0;
            rsp_attr_o <= '0;
        end else begin
            rsp_vld_o  <= lkp_go;
            rsp_hit_o  <= lkp_go && any_hit;
            rsp_phys_o <= (lkp_go && any_hit) ? {sel_pfn, lkp_lin_i[OFS_W-1:0]} : '0;
            rsp_attr_o <= (lkp_go && any_hit) ? 3'(sel_attr) : '0;
        end
    end
endmodule

// File: rtl/tlb4w_chk.sv
// Property checker for the translation cache, bound to every tlb4w instance.
// Assumes: synchronous active-low reset; observes ports and the per-way hit vector.
module tlb4w_chk #(
    parameter int WAYS  = 4,
    parameter int LIN_W = 32,
    parameter int PHY_W = 32,
    parameter int OFS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             lkp_req_i,
    input logic [LIN_W-1:0] lkp_lin_i,
    input logic             fill_req_i,
    input logic             rsp_vld_o,
    input logic             rsp_hit_o,
    input logic [PHY_W-1:0] rsp_phys_o,
    input logic [2:0]       rsp_attr_o,
    input logic [WAYS-1:0]  hit_vec
);
    logic flush_q;

    // Remember a flush from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush_i;
    end

    p_no_hit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld_o |-> !rsp_hit_o);
    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req_i && !fill_req_i |=> rsp_vld_o);
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req_i && !fill_req_i |=>
            (!rsp_hit_o || rsp_phys_o[OFS_W-1:0] == $past(lkp_lin_i[OFS_W-1:0])));
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o && !rsp_hit_o |-> (rsp_phys_o == '0 && rsp_attr_o == '0));
    p_fill_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_i |=> !rsp_vld_o);
    p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    p_flush_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q && lkp_req_i && !fill_req_i |=> !rsp_hit_o);
endmodule

bind tlb4w tlb4w_chk #(
    .WAYS (WAYS),
    .LIN_W(LIN_W),
    .PHY_W(PHY_W),
    .OFS_W(OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .lkp_req_i (lkp_req_i),
    .lkp_lin_i (lkp_lin_i),
    .fill_req_i(fill_req_i),
    .rsp_vld_o (rsp_vld_o),
    .rsp_hit_o (rsp_hit_o),
    .rsp_phys_o(rsp_phys_o),
    .rsp_attr_o(rsp_attr_o),
    .hit_vec   (hit_vec)
);

// File: tb/tlb4w_bench.sv
`timescale 1ns/1ps
// Directed bench for tlb4w: one task per scenario, each checking its own results.
module tlb4w_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lkp_req_i = 1'b0;
    logic [31:0] lkp_lin_i = '0;
    logic        fill_req_i = 1'b0;
    logic [19:0] fill_vpn_i = '0;
    logic [19:0] fill_pfn_i = '0;
    logic [2:0]  fill_attr_i = '0;
    logic        rsp_vld_o, rsp_hit_o;
    logic [31:0] rsp_phys_o;
    logic [2:0]  rsp_attr_o;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tlb4w u_tlb4w (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lkp_req_i(lkp_req_i), .lkp_lin_i(lkp_lin_i),
        .fill_req_i(fill_req_i), .fill_vpn_i(fill_vpn_i),
        .fill_pfn_i(fill_pfn_i), .fill_attr_i(fill_attr_i),
        .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o),
        .rsp_phys_o(rsp_phys_o), .rsp_attr_o(rsp_attr_o)
    );

    function automatic logic [19:0] mk_vpn(int n, int set);
        return {17'(n), 3'(set)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Lookup one address; all tasks start and end at a falling edge.
    task automatic lookup(string req, logic [19:0] vpn, logic [11:0] ofs,
                          bit exp_hit, logic [19:0] exp_pfn, logic [2:0] exp_attr);
        lkp_req_i = 1'b1;
        lkp_lin_i = {vpn, ofs};
        @(negedge clk);
        lkp_req_i = 1'b0;
        check(req, {rsp_vld_o, rsp_hit_o}, {1'b1, exp_hit});
        check(req, rsp_phys_o, exp_hit ? {exp_pfn, ofs} : 32'h0);
        check(req, rsp_attr_o, exp_hit ? exp_attr : 3'b0);
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [2:0] attr);
        fill_req_i  = 1'b1;
        fill_vpn_i  = vpn;
        fill_pfn_i  = pfn;
        fill_attr_i = attr;
        @(negedge clk);
        fill_req_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {rsp_vld_o, rsp_hit_o, rsp_phys_o, rsp_attr_o}, 64'h0);
        lookup("R1 empty miss", 20'h0, 12'h0, 0, 0, 0);
        @(negedge clk);
        check("R2 idle no valid", {rsp_vld_o, rsp_hit_o}, 2'b00);
    endtask

    task automatic t_hit_miss;
        fill(20'hABCD1, 20'h12345, 3'b101);
        lookup("R6 R3 hit after fill", 20'hABCD1, 12'h7E4, 1, 20'h12345, 3'b101);
        lookup("R3 offset zero", 20'hABCD1, 12'h000, 1, 20'h12345, 3'b101);
        lookup("R4 same set other page", 20'hABCD9, 12'h123, 0, 0, 0);
        lookup("R4 other set", 20'hABCD2, 12'hFFF, 0, 0, 0);
    endtask

    task automatic t_collide;
        fill_req_i = 1'b1; fill_vpn_i = 20'h0F0F2;
        fill_pfn_i = 20'h55555; fill_attr_i = 3'b011;
        lkp_req_i  = 1'b1; lkp_lin_i = {20'hABCD1, 12'h010};
        @(negedge clk);
        fill_req_i = 1'b0; lkp_req_i = 1'b0;
        check("R5 lookup dropped", rsp_vld_o, 1'b0);
        lookup("R5 fill done", 20'h0F0F2, 12'h020, 1, 20'h55555, 3'b011);
    endtask

    task automatic t_round_robin;
        for (int i = 0; i < 4; i++) fill(mk_vpn(16 + i, 5), 20'hA0000 + 20'(i), 3'b001);
        for (int i = 0; i < 4; i++)
            lookup("R7 invalid ways first", mk_vpn(16 + i, 5), 12'h004, 1, 20'hA0000 + 20'(i), 3'b001);
        fill(mk_vpn(20, 5), 20'hA0004, 3'b010);
        fill(mk_vpn(21, 5), 20'hA0005, 3'b010);
        lookup("R8 way0 evicted", mk_vpn(16, 5), 12'h0, 0, 0, 0);
        lookup("R8 way1 evicted", mk_vpn(17, 5), 12'h0, 0, 0, 0);
        lookup("R8 way2 kept", mk_vpn(18, 5), 12'h0, 1, 20'hA0002, 3'b001);
        lookup("R8 new entry", mk_vpn(21, 5), 12'h0, 1, 20'hA0005, 3'b010);
        for (int i = 0; i < 5; i++) fill(mk_vpn(40 + i, 6), 20'hB0000 + 20'(i), 3'b100);
        lookup("R11 other set evicts own way0", mk_vpn(40, 6), 12'h0, 0, 0, 0);
        fill(mk_vpn(22, 5), 20'hA0006, 3'b111);
        lookup("R11 set pointer kept", mk_vpn(18, 5), 12'h0, 0, 0, 0);
        lookup("R11 way3 kept", mk_vpn(19, 5), 12'h0, 1, 20'hA0003, 3'b001);
        lookup("R11 new entry", mk_vpn(22, 5), 12'h0, 1, 20'hA0006, 3'b111);
    endtask

    task automatic t_refill;
        for (int i = 0; i < 4; i++) fill(mk_vpn(60 + i, 3), 20'hC0000 + 20'(i), 3'b000);
        fill(mk_vpn(61, 3), 20'hDDDDD, 3'b110);
        lookup("R9 refreshed entry", mk_vpn(61, 3), 12'h321, 1, 20'hDDDDD, 3'b110);
        for (int i = 0; i < 4; i++)
            if (i != 1)
                lookup("R9 no eviction", mk_vpn(60 + i, 3), 12'h0, 1, 20'hC0000 + 20'(i), 3'b000);
    endtask

    task automatic t_flush;
        flush_i = 1'b1; lkp_req_i = 1'b1; lkp_lin_i = {mk_vpn(60, 3), 12'h0AA};
        @(negedge clk);
        flush_i = 1'b0; lkp_req_i = 1'b0;
        check("R10 flush-cycle lookup", {rsp_vld_o, rsp_hit_o, rsp_phys_o}, {2'b11, 20'hC0000, 12'h0AA});
        lookup("R10 miss after flush", mk_vpn(60, 3), 12'h0AA, 0, 0, 0);
        lookup("R10 all cleared", 20'hABCD1, 12'h0, 0, 0, 0);
        flush_i = 1'b1; fill_req_i = 1'b1; fill_vpn_i = 20'h77777;
        fill_pfn_i = 20'h11111; fill_attr_i = 3'b111;
        @(negedge clk);
        flush_i = 1'b0; fill_req_i = 1'b0;
        lookup("R10 fill in flush discarded", 20'h77777, 12'h0, 0, 0, 0);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_miss();
        t_collide();
        t_round_robin();
        t_refill();
        t_flush();
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule